// File: doc/BRIEF.md
# Prioritized Pending Interrupt Selector

This block holds a set of pending interrupt events for up to 32 sources and hands them out one at a time, in priority order. Each source can be given a priority level through a small configuration write port. A source that has never been given a level belongs to no level at all. On every request pulse the block picks one pending source, clears only that source's pending bit, and returns the source number one clock later. When the held set is empty, a request first loads the event vector presented on `cap_vec` as a fresh capture. If that vector is also empty, the response carries the code 255, meaning "nothing to service".

The selection works in two stages. First, the priority masks of all pending sources are ORed together, and the highest level that appears in the result wins. Second, the highest-numbered pending source that is a member of the winning level is chosen. If no pending source has a level, the block falls back to the highest-numbered pending source. It also falls back the same way if the winning level somehow contains no pending member. The per-level membership masks are rebuilt from the per-source settings on every configuration write. A write lands at a clock edge, and the rebuilt masks are in force for any request from the following cycle on.

Top module: `irq_pick_sel`

## Requirements
- R1: After reset, `rsp_valid` is low, no event is held, and every source is unassigned (it belongs to no level).
- R2: `rsp_valid` is high in the cycle after each cycle with `req` high, and low in the cycle after each cycle with `req` low.
- R3: A request made while no event is held takes `cap_vec` as the new pending set. If `cap_vec` is zero, the response is 255 and the pending set stays empty.
- R4: A request made while events are held ignores `cap_vec`; no bit of it enters the pending set.
- R5: When exactly one source is pending, a request returns that source number and leaves the pending set empty.
- R6: When several sources are pending, the response is the highest-numbered pending source among those at the highest level held by any pending source.
- R7: Each request clears only the returned source's pending bit; all other pending bits remain for later requests.
- R8: A written level value is clamped to the range 0 to 8. Level 8 outranks level 7, and a written value of 9 to 15 behaves as 8.
- R9: An unassigned source belongs to no level. If every pending source is unassigned, the highest-numbered pending source is returned.
- R10: A configuration write in cycle N is used by requests from cycle N+1 on. A request in cycle N itself uses the previous assignment.
- R11: Reassigning a source removes it from its former level, because the level membership is rebuilt from all sources on every write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Selection request, one per cycle |
| cap_vec | input | 32 | Fresh event capture, loaded only by a request while nothing is held |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src | input | 5 | Source whose level is written |
| cfg_pri | input | 4 | Requested level, clamped to 0..8 |
| rsp_valid | output | 1 | Response valid, one cycle after `req` |
| rsp_src | output | 8 | Selected source number, or 255 when nothing is pending |

## Verification
The bench builds the block with its defaults: 32 sources, 8 as the top level, and a 4-bit level input. These defaults put three corners within reach. Source 31 is the highest-numbered source. Written values 9 to 15 clamp to level 8. The 8-bit response can carry the code 255. Directed sequences cover each ordering rule, and a seeded random phase then mixes captures, requests and writes in the same cycle. A behavioural model in the bench checks the response on every clock.

// File: rtl/irq_pick_pkg.sv
`timescale 1ns/1ps
package irq_pick_pkg;
    localparam int unsigned NSRC_DEF = 32;
    localparam int unsigned NLVL_DEF = 8;
    localparam int unsigned PRIW_DEF = 4;
    localparam int unsigned RSPW     = 8;
    localparam logic [RSPW-1:0] NONE_CODE = 8'hFF;
endpackage

// File: rtl/irq_pick_cfg.sv
`timescale 1ns/1ps
// Per-source level storage (one-hot) and per-level membership rebuild.
module irq_pick_cfg #(
    parameter int unsigned NSRC = irq_pick_pkg::NSRC_DEF,
    parameter int unsigned NLVL = irq_pick_pkg::NLVL_DEF,
    parameter int unsigned PRIW = irq_pick_pkg::PRIW_DEF,
    localparam int unsigned SRCW = $clog2(NSRC),
    localparam int unsigned LW   = NLVL + 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [SRCW-1:0]                src,
    input  logic [PRIW-1:0]                pri,
    output logic [NSRC-1:0][LW-1:0]        pri_mask,
    output logic [LW-1:0][NSRC-1:0]        lvl_mask
);
    typedef struct packed {
        logic [NSRC-1:0][LW-1:0] pri;
        logic [LW-1:0][NSRC-1:0] lvl;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic [PRIW-1:0] clamped;

    always_comb begin
        st_d    = st_q;
        clamped = (pri > PRIW'(NLVL)) ? PRIW'(NLVL) : pri;
        if (we) begin
            st_d.pri[src] = LW'(1) << clamped;
        end
        // full rebuild of every level's membership from all sources
        for (int l = 0; l < int'(LW); l++) begin
            for (int i = 0; i < int'(NSRC); i++) begin
                st_d.lvl[l][i] = st_d.pri[i][l];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pri_mask = st_q.pri;
    assign lvl_mask = st_q.lvl;

    // R8: large values land on the top level
    a_r8_clamp_top: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (pri > PRIW'(NLVL))) |=> pri_mask[$past(src)][NLVL]);

    // R11: after a write the source is a member of exactly one level
    a_r11_single_level: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> $onehot(pri_mask[$past(src)]));
endmodule

// File: rtl/irq_pick_core.sv
`timescale 1ns/1ps
// Combinational choice: winning level, then highest member, with fallback.
module irq_pick_core #(
    parameter int unsigned NSRC = irq_pick_pkg::NSRC_DEF,
    parameter int unsigned NLVL = irq_pick_pkg::NLVL_DEF,
    localparam int unsigned SRCW = $clog2(NSRC),
    localparam int unsigned LW   = NLVL + 1,
    localparam int unsigned LVLW = $clog2(LW)
) (
    input  logic [NSRC-1:0]           work,
    input  logic [NSRC-1:0][LW-1:0]   pri_mask,
    input  logic [LW-1:0][NSRC-1:0]   lvl_mask,
    output logic                      any,
    output logic [SRCW-1:0]           pick
);
    logic [LW-1:0]   prio_or;
    logic [LVLW-1:0] top_lvl;
    logic [NSRC-1:0] cand;
    logic            single;

    always_comb begin
        prio_or = '0;
        for (int i = 0; i < int'(NSRC); i++) begin
            if (work[i]) prio_or = prio_or | pri_mask[i];
        end
        top_lvl = '0;
        for (int l = 0; l < int'(LW); l++) begin
            if (prio_or[l]) top_lvl = LVLW'(l);
        end
        single = $onehot(work);
        if (single || prio_or == '0) begin
            cand = work;
        end else begin
            cand = work & lvl_mask[top_lvl];
            if (cand == '0) cand = work;   // spurious: take the highest overall
        end
        pick = '0;
        for (int i = 0; i < int'(NSRC); i++) begin
            if (cand[i]) pick = SRCW'(i);
        end
        any = (work != '0);
    end

    // R6: the chosen source is always one of the pending ones
    always_comb begin
        if (any) a_r6_pick_is_pending: assert (work[pick]);
    end
endmodule

// File: rtl/irq_pick_sel.sv
`timescale 1ns/1ps
module irq_pick_sel #(
    parameter int unsigned NSRC = irq_pick_pkg::NSRC_DEF,
    parameter int unsigned NLVL = irq_pick_pkg::NLVL_DEF,
    parameter int unsigned PRIW = irq_pick_pkg::PRIW_DEF,
    localparam int unsigned SRCW = $clog2(NSRC),
    localparam int unsigned LW   = NLVL + 1,
    localparam int unsigned RSPW = irq_pick_pkg::RSPW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [NSRC-1:0]   cap_vec,
    input  logic              cfg_we,
    input  logic [SRCW-1:0]   cfg_src,
    input  logic [PRIW-1:0]   cfg_pri,
    output logic              rsp_valid,
    output logic [RSPW-1:0]   rsp_src
);
    typedef struct packed {
        logic [NSRC-1:0] pending;
        logic            valid;
        logic [RSPW-1:0] src;
    } sel_st_t;

    sel_st_t st_d, st_q;

    logic [NSRC-1:0][LW-1:0] pri_mask;
    logic [LW-1:0][NSRC-1:0] lvl_mask;
    logic [NSRC-1:0]         work;
    logic                    any;
    logic [SRCW-1:0]         pick;

    irq_pick_cfg #(.NSRC(NSRC), .NLVL(NLVL), .PRIW(PRIW)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .src      (cfg_src),
        .pri      (cfg_pri),
        .pri_mask (pri_mask),
        .lvl_mask (lvl_mask)
    );

    // a fresh capture is used only when nothing is held
    assign work = (st_q.pending != '0) ? st_q.pending : cap_vec;

    irq_pick_core #(.NSRC(NSRC), .NLVL(NLVL)) core_i (
        .work     (work),
        .pri_mask (pri_mask),
        .lvl_mask (lvl_mask),
        .any      (any),
        .pick     (pick)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = req;
        if (req) begin
            if (any) begin
                st_d.src     = RSPW'(pick);
                st_d.pending = work & ~(NSRC'(1) << pick);
            end else begin
                st_d.src     = irq_pick_pkg::NONE_CODE;
                st_d.pending = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.valid;
    assign rsp_src   = st_q.src;

    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid);

    a_r2_no_unasked_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid);

    a_r3_none_code: assert property (@(posedge clk) disable iff (!rst_n)
        (req && st_q.pending == '0 && cap_vec == '0) |=> (rsp_src == irq_pick_pkg::NONE_CODE));

    a_r4_no_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (req && st_q.pending != '0) |=> ((st_q.pending & ~$past(st_q.pending)) == '0));

    a_r5_single_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (req && $onehot(work)) |=> (st_q.pending == '0));

    a_r7_one_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (req && st_q.pending != '0) |=> ($countones(st_q.pending) + 1 == $countones($past(st_q.pending))));
endmodule

// File: tb/irq_pick_sel_tb_top.sv
`timescale 1ns/1ps
module irq_pick_sel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [31:0] cap_vec = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_src = '0;
    logic [3:0]  cfg_pri = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_src;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int          lvl_m [32];
    logic [31:0] pend_m;
    bit          exp_valid;
    int          exp_src;

    always #4 clk = ~clk;

    irq_pick_sel dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .cap_vec(cap_vec),
        .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_pri(cfg_pri),
        .rsp_valid(rsp_valid), .rsp_src(rsp_src)
    );

    function automatic int model_pick(input logic [31:0] w);
        int best = -1;
        int sel  = -1;
        for (int i = 0; i < 32; i++) if (w[i] && lvl_m[i] > best) best = lvl_m[i];
        for (int i = 0; i < 32; i++) begin
            if (w[i] && (best < 0 || lvl_m[i] == best)) sel = i;
        end
        return sel;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit rq, input logic [31:0] cv, input bit we,
                        input int s, input int p, input string tag);
        logic [31:0] w;
        int          k;
        req = rq; cap_vec = cv; cfg_we = we; cfg_src = 5'(s); cfg_pri = 4'(p);
        exp_valid = rq;
        if (rq) begin
            w = (pend_m != 0) ? pend_m : cv;
            if (w == 0) begin
                exp_src = 255;
            end else begin
                k = model_pick(w);
                exp_src = k;
                pend_m = w & ~(32'd1 << k);
            end
        end
        if (we) lvl_m[s] = (p > 8) ? 8 : p;   // R8 clamp; R10 applies after this cycle
        @(posedge clk);
        @(negedge clk);
        check(rsp_valid == exp_valid, {tag, " valid"}, int'(rsp_valid), int'(exp_valid));
        if (exp_valid) check(int'(rsp_src) == exp_src, {tag, " src"}, int'(rsp_src), exp_src);
        req = 0; cfg_we = 0;
    endtask

    task automatic wr(input int s, input int p, input string tag);
        step(0, 0, 1, s, p, tag);
    endtask

    task automatic rq(input logic [31:0] cv, input string tag);
        step(1, cv, 0, 0, 0, tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) lvl_m[i] = -1;
        pend_m = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 reset valid", int'(rsp_valid), 0);
        rq(32'h0, "R1 R3 empty");
        step(0, 32'hFFFF_FFFF, 0, 0, 0, "R2 idle");
        rq(32'h0000_0010, "R5 single");
        rq(32'h0, "R5 R3 emptied");
        // unassigned sources only
        rq(32'h8000_0003, "R9 unassigned");
        rq(32'h0, "R9 R7 remaining");
        rq(32'hFFFF_0000, "R4 ignored cap");
        rq(32'h0, "R7 last");
        rq(32'h0, "R3 none");
        // assign levels
        wr(3, 2, "R8 write");
        wr(10, 5, "R8 write");
        wr(20, 5, "R8 write");
        wr(7, 15, "R8 write");
        wr(9, 7, "R8 write");
        rq(32'h8010_0408, "R6 level five");
        rq(32'h0, "R6 R7 within level");
        rq(32'h0, "R6 next level");
        rq(32'h0, "R9 unassigned last");
        rq(32'h0000_0280, "R8 clamp outranks");
        rq(32'h0, "R8 second");
        // R10: write and request in one cycle
        rq(32'h0000_0408, "R10 prep");       // takes 10, leaves 3
        step(1, 0, 1, 3, 12, "R10 same cycle");
        rq(32'h0000_0408, "R10 after");       // 3 now level 8
        rq(32'h0, "R10 tail");
        // R11 reassignment
        wr(20, 0, "R11 move");
        rq(32'h0010_0401, "R11 moved out");
        rq(32'h0, "R11 next");
        rq(32'h0, "R11 last");
        // seeded random mix
        void'($urandom(32'd77));
        for (int n = 0; n < 600; n++) begin
            logic [31:0] cv;
            cv = $urandom() & $urandom() & $urandom();
            step(($urandom() % 10) < 6, cv, ($urandom() % 4) == 0,
                 int'($urandom() % 32), int'($urandom() % 16), "R6 R7 R10 random");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule